// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Ripple Blanking

This block turns one binary-coded decimal digit into the drive pattern for a seven-segment display. A segment is lit when its output is high. Two control inputs choose what the digit position shows. The first is an enable. The second is a blanking input, which comes from the more significant neighbour. Together they select lamp test, forced dark, zero suppression or normal display.

The block also drives a blanking output that is passed down a chain of digits. A digit that suppresses its own zero keeps this output low, so the next position can suppress its zero as well. Lamp test keeps this output low too, so lamp test spreads down the chain. An invalid code drives the output high, so it never behaves like a suppressed zero.

Both outputs are registered on the block clock. A new input combination appears at the outputs one clock after it is sampled. The block holds no other state.

Top module: `bcdseg_decoder`

## Requirements
- R1: With enable_i=0 and rbi_i=0 (lamp test), all seven segment bits are high and rbo_o is low, whatever the digit.
- R2: With enable_i=0 and rbi_i=1, all segment bits are low and rbo_o is high, whatever the digit.
- R3: With enable_i=1, rbi_i=0 and digit 0, all segment bits are low and rbo_o is low (zero suppressed).
- R4: With enable_i=1, rbi_i=1 and digit 0, seg_o shows zero: segments a to f on, g off (7'h3F), and rbo_o is high.
- R5: With enable_i=1 and a digit from 1 to 9, the glyph is shown whatever rbi_i is, and rbo_o is high. Segment bit 0 is a, bit 1 is b, and so on up to bit 6, which is g. The glyphs are: 1=7'h06, 2=7'h5B, 3=7'h4F, 4=7'h66, 5=7'h6D, 8=7'h7F.
- R6: Digit 6 lights a, c, d, e, f and g (7'h7D). Digit 7 lights only a, b and c (7'h07). Digit 9 lights a, b, c, f and g, with d off (7'h67).
- R7: With enable_i=1 and a code from 10 to 15, all segment bits are low and rbo_o is high, whatever rbi_i is.
- R8: The outputs follow the inputs that were sampled at the previous rising clock edge. There is exactly one register stage.
- R9: A synchronous active-high rst drives seg_o to all zeros and rbo_o high at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_i | input | 4 | BCD digit; bit 0 is the least significant bit |
| enable_i | input | 1 | Enable; low selects lamp test or forced dark |
| rbi_i | input | 1 | Blanking input from the more significant digit |
| seg_o | output | 7 | Registered segments; bit 0 is a, bit 6 is g |
| rbo_o | output | 1 | Registered blanking output to the less significant digit |

## Verification
The assertions assume that digit_i, enable_i and rbi_i hold known values whenever rst is low. They also assume these inputs are stable around each rising edge, because every property reads the inputs from the previous edge. The stimulus changes the inputs only on falling clock edges and keeps reset high until the inputs are defined. It applies all 64 input combinations in ascending order, then again in descending order, so each mode is entered from several different modes. A reset pulse in the middle of the run checks that the outputs return to the dark, non-blanking value.

// File: rtl/bcdseg_pkg.sv
package bcdseg_pkg;
  localparam int SEG_COUNT = 7;

  typedef enum logic [1:0] {
    MODE_LAMP     = 2'd0,
    MODE_DARK     = 2'd1,
    MODE_SUPPRESS = 2'd2,
    MODE_SHOW     = 2'd3
  } disp_mode_e;
endpackage

// File: rtl/bcdseg_mode_dec.sv
module bcdseg_mode_dec
  import bcdseg_pkg::*;
(
  input  logic       enable_i,
  input  logic       rbi_i,
  input  logic       is_zero_i,
  output disp_mode_e mode_o
);
  always_comb begin
    if (!enable_i)
      mode_o = rbi_i ? MODE_DARK : MODE_LAMP;
    else if (is_zero_i && !rbi_i)
      mode_o = MODE_SUPPRESS;
    else
      mode_o = MODE_SHOW;
  end
endmodule

// File: rtl/bcdseg_glyph.sv
module bcdseg_glyph #(
  parameter int DIGIT_W = 4,
  parameter int SEG_N   = 7
) (
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [SEG_N-1:0]   glyph_o,
  output logic               valid_o,
  output logic               is_zero_o
);
  localparam int MAX_DIGIT = 9;

  logic [6:0] pat;

  always_comb begin
    case (digit_i)
      DIGIT_W'(0): pat = 7'h3F;
      DIGIT_W'(1): pat = 7'h06;
      DIGIT_W'(2): pat = 7'h5B;
      DIGIT_W'(3): pat = 7'h4F;
      DIGIT_W'(4): pat = 7'h66;
      DIGIT_W'(5): pat = 7'h6D;
      DIGIT_W'(6): pat = 7'h7D;
      DIGIT_W'(7): pat = 7'h07;
      DIGIT_W'(8): pat = 7'h7F;
      DIGIT_W'(9): pat = 7'h67;
      default:     pat = 7'h00;
    endcase
  end

  assign glyph_o   = SEG_N'(pat);
  assign valid_o   = (digit_i <= DIGIT_W'(MAX_DIGIT));
  assign is_zero_o = (digit_i == '0);
endmodule

// File: rtl/bcdseg_out_sel.sv
module bcdseg_out_sel
  import bcdseg_pkg::*;
#(
  parameter int SEG_N = 7
) (
  input  disp_mode_e       mode_i,
  input  logic [SEG_N-1:0] glyph_i,
  input  logic             valid_i,
  output logic [SEG_N-1:0] seg_o,
  output logic             rbo_o
);
  logic lamp_on;
  logic show_on;

  assign lamp_on = (mode_i == MODE_LAMP);
  assign show_on = (mode_i == MODE_SHOW) && valid_i;

  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    assign seg_o[s] = lamp_on | (show_on & glyph_i[s]);
  end

  assign rbo_o = !((mode_i == MODE_LAMP) || (mode_i == MODE_SUPPRESS));
endmodule

// File: rtl/bcdseg_decoder.sv
module bcdseg_decoder
  import bcdseg_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int SEG_N   = SEG_COUNT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               enable_i,
  input  logic               rbi_i,
  output logic [SEG_N-1:0]   seg_o,
  output logic               rbo_o
);
  localparam int MAX_DIGIT = 9;

  disp_mode_e       mode;
  logic [SEG_N-1:0] glyph;
  logic             valid;
  logic             is_zero;
  logic [SEG_N-1:0] seg_nxt;
  logic             rbo_nxt;

  bcdseg_glyph #(.DIGIT_W(DIGIT_W), .SEG_N(SEG_N)) u_glyph (
    .digit_i   (digit_i),
    .glyph_o   (glyph),
    .valid_o   (valid),
    .is_zero_o (is_zero)
  );

  bcdseg_mode_dec u_mode (
    .enable_i  (enable_i),
    .rbi_i     (rbi_i),
    .is_zero_i (is_zero),
    .mode_o    (mode)
  );

  bcdseg_out_sel #(.SEG_N(SEG_N)) u_sel (
    .mode_i  (mode),
    .glyph_i (glyph),
    .valid_i (valid),
    .seg_o   (seg_nxt),
    .rbo_o   (rbo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_o <= '0;
      rbo_o <= 1'b1;
    end else begin
      seg_o <= seg_nxt;
      rbo_o <= rbo_nxt;
    end
  end

  // Output register guards
  assert_lamp_test_R1: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !rbi_i) |=> (seg_o == '1 && !rbo_o));

  assert_forced_dark_R2: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && rbi_i) |=> (seg_o == '0 && rbo_o));

  assert_zero_suppress_R3: assert property (@(posedge clk) disable iff (rst)
    (enable_i && !rbi_i && digit_i == '0) |=> (seg_o == '0 && !rbo_o));

  assert_zero_shown_R4: assert property (@(posedge clk) disable iff (rst)
    (enable_i && rbi_i && digit_i == '0) |=> (seg_o == SEG_N'(7'h3F) && rbo_o));

  assert_digit_lit_R5: assert property (@(posedge clk) disable iff (rst)
    (enable_i && digit_i != '0 && digit_i <= DIGIT_W'(MAX_DIGIT))
      |=> (seg_o != '0 && rbo_o));

  assert_bad_code_dark_R7: assert property (@(posedge clk) disable iff (rst)
    (enable_i && digit_i > DIGIT_W'(MAX_DIGIT)) |=> (seg_o == '0 && rbo_o));

  assert_rbo_low_uniform_R8: assert property (@(posedge clk) disable iff (rst)
    !rbo_o |-> (seg_o == '0 || seg_o == '1));

  assert_reset_value_R9: assert property (@(posedge clk)
    rst |=> (seg_o == '0 && rbo_o));
endmodule

// File: tb/bcdseg_decoder_tb.sv
module bcdseg_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit_i = '0;
  logic       enable_i = 1'b0;
  logic       rbi_i = 1'b1;
  logic [6:0] seg_o;
  logic       rbo_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bcdseg_decoder u_dut (
    .clk(clk), .rst(rst), .digit_i(digit_i),
    .enable_i(enable_i), .rbi_i(rbi_i),
    .seg_o(seg_o), .rbo_o(rbo_o)
  );

  function automatic logic [6:0] from_letters(string s);
    logic [6:0] v = '0;
    for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
    return v;
  endfunction

  function automatic logic [6:0] shape(int d);
    case (d)
      0: return from_letters("abcdef");
      1: return from_letters("bc");
      2: return from_letters("abdeg");
      3: return from_letters("abcdg");
      4: return from_letters("bcfg");
      5: return from_letters("acdfg");
      6: return from_letters("acdefg");
      7: return from_letters("abc");
      8: return from_letters("abcdefg");
      9: return from_letters("abcfg");
      default: return 7'h00;
    endcase
  endfunction

  // Expected result of the previous cycle's inputs
  logic [6:0] exp_seg;
  logic       exp_rbo;
  string      exp_tag;
  bit         pending = 0;

  task automatic model(input bit r, input int d, input bit en, input bit rb);
    if (r) begin exp_seg = 7'h00; exp_rbo = 1; exp_tag = "R9"; end
    else if (!en && !rb) begin exp_seg = 7'h7F; exp_rbo = 0; exp_tag = "R1"; end
    else if (!en) begin exp_seg = 7'h00; exp_rbo = 1; exp_tag = "R2"; end
    else if (d > 9) begin exp_seg = 7'h00; exp_rbo = 1; exp_tag = "R7"; end
    else if (d == 0 && !rb) begin exp_seg = 7'h00; exp_rbo = 0; exp_tag = "R3"; end
    else if (d == 0) begin exp_seg = shape(0); exp_rbo = 1; exp_tag = "R4"; end
    else begin
      exp_seg = shape(d); exp_rbo = 1;
      exp_tag = (d == 6 || d == 7 || d == 9) ? "R6" : "R5";
    end
  endtask

  task automatic compare();
    checks++;
    if (seg_o !== exp_seg || rbo_o !== exp_rbo) begin
      failures++;
      $display("FAIL %s (R8 timing) seg=%h rbo=%b expected seg=%h rbo=%b",
               exp_tag, seg_o, rbo_o, exp_seg, exp_rbo);
    end
  endtask

  // Drive on falling edge, check previous cycle's expectation first
  task automatic step(input bit r, input int d, input bit en, input bit rb);
    @(negedge clk);
    if (pending) compare();
    rst = r; digit_i = 4'(d); enable_i = en; rbi_i = rb;
    model(r, d, en, rb);
    pending = 1;
  endtask

  initial begin
    step(1, 0, 0, 1);
    step(1, 5, 1, 1);
    step(1, 8, 0, 0);
    // R1..R7 ascending sweep
    for (int k = 0; k < 64; k++) step(0, k % 16, k[5], k[4]);
    // descending sweep: different mode transitions
    for (int k = 63; k >= 0; k--) step(0, k % 16, k[4], k[5]);
    // R9: reset pulse mid-run after a lamp test
    step(0, 3, 0, 0);
    step(1, 3, 0, 0);
    step(0, 9, 1, 0);
    step(0, 0, 1, 0);
    step(0, 0, 1, 1);
    step(0, 12, 1, 0);
    @(negedge clk);
    compare();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule